// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the registers that software uses to program one DMA channel. It sits behind a 32-bit register bus that accepts full-word accesses only. The bus sees a command/status word and five address pointers. The pointers hold the current and initial buffer address, a limit, and a start/stop pair. They are ordinary read/write storage.

The command/status word does not store what is written to it. Each write is decoded as a set of commands: raise the enable flag, raise the chaining-update flag, mark the transfer direction as device-to-memory, drop the complete flag, or clear every flag at once. A read of the same offset returns the four status flags.

The transfer engine is not part of this block. It reports a finished transfer through a single-cycle completion input, which raises the complete flag while the channel is enabled.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register (status flags and all five pointers) reads as zero.
- R2: An access takes effect only when all four byte enables are set; a write with any other byte-enable pattern changes nothing, and such a read returns zero.
- R3: The pointer registers at offsets 0x4000, 0x4004, 0x4008, 0x400C and 0x4200 read back the full 32-bit value last written to them.
- R4: A read of offset 0x0 returns enable in bit 0, update in bit 1, complete in bit 3 and direction in bit 4, with every other bit zero.
- R5: A control write with bit 16 set raises enable; a control write with bit 16 clear does not lower it.
- R6: A control write with bit 17 set raises the update flag; writing bit 17 clear does not lower it.
- R7: A control write with bit 18 set raises the direction flag; writing bit 18 clear does not lower it.
- R8: A control write with bit 19 set clears the complete flag and leaves enable, update and direction unchanged.
- R9: A control write with bit 20 set clears all four flags, even when the same write also carries bits 16, 17 or 18, and it leaves the pointers unchanged.
- R10: A completion pulse raises the complete flag only if enable is already set; when a bit-19 write arrives in the same cycle, the flag ends up clear.
- R11: Reads of unmapped or misaligned offsets return zero, and writes to them change no register.
- R12: A register written at one clock edge reads back its new value in the cycle right after that edge, and read data depends only on the inputs of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF is honoured |
| bus_addr | input | 16 | Byte offset within the channel |
| bus_wdata | input | 32 | Write data or command word |
| bus_rdata | output | 32 | Read data, combinational |
| done_pulse | input | 1 | One-cycle transfer-complete event |

## Verification
Writes and completion pulses update the registers at the next rising edge. Reads are combinational, so a result is due in the cycle after its stimulus. The bench applies every stimulus on a falling edge and lowers it on the next falling edge. It then drives the read address straight away and samples 1 ns later. Each check therefore falls in the first cycle in which the new value is valid, with no settling margin. The cases where a completion pulse and a command write arrive together are driven in one shared cycle, so the bench checks the priority order and not two separate events.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // command bit positions inside a control-register write
  localparam int CMD_LO      = 16;
  localparam int CMD_W       = 5;
  localparam int CMD_SET_EN  = 16;
  localparam int CMD_SET_UPD = 17;
  localparam int CMD_DEV2MEM = 18;
  localparam int CMD_CLR_CMP = 19;
  localparam int CMD_RESET   = 20;

  // status bit positions on a control-register read
  localparam int ST_EN  = 0;
  localparam int ST_UPD = 1;
  localparam int ST_CMP = 3;
  localparam int ST_DIR = 4;

  localparam logic [15:0] CTRL_OFS = 16'h0000;

  typedef struct packed {
    logic dir;
    logic cmp;
    logic upd;
    logic en;
  } flags_t;

  // pointers 0..3 form a contiguous block, later ones start a second block
  function automatic logic [15:0] ptr_offset(input int idx);
    if (idx < 4) return 16'h4000 + 16'(4 * idx);
    else         return 16'h4200 + 16'(4 * (idx - 4));
  endfunction

  function automatic logic [31:0] pack_status(input flags_t f);
    logic [31:0] r;
    r         = '0;
    r[ST_EN]  = f.en;
    r[ST_UPD] = f.upd;
    r[ST_CMP] = f.cmp;
    r[ST_DIR] = f.dir;
    return r;
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NPTR   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_hit,
  output logic [NPTR-1:0]   ptr_hit,
  output logic              any_hit
);
  assign ctrl_hit = (addr == ADDR_W'(CTRL_OFS));

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr_dec
    assign ptr_hit[i] = (addr == ADDR_W'(ptr_offset(i)));
  end

  assign any_hit = ctrl_hit | (|ptr_hit);
endmodule

// File: rtl/dma_ctrl_flags.sv
module dma_ctrl_flags
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [CMD_W-1:0] cmd,
  input  logic             done_pulse,
  output flags_t           flags
);
  flags_t flags_q;
  flags_t flags_d;
  logic   c_en, c_upd, c_dir, c_clr, c_rst;

  always_comb begin
    c_en  = ctrl_wr & cmd[CMD_SET_EN  - CMD_LO];
    c_upd = ctrl_wr & cmd[CMD_SET_UPD - CMD_LO];
    c_dir = ctrl_wr & cmd[CMD_DEV2MEM - CMD_LO];
    c_clr = ctrl_wr & cmd[CMD_CLR_CMP - CMD_LO];
    c_rst = ctrl_wr & cmd[CMD_RESET   - CMD_LO];

    flags_d = flags_q;
    if (c_rst) begin
      flags_d = '0;
    end else begin
      flags_d.en  = flags_q.en  | c_en;
      flags_d.upd = flags_q.upd | c_upd;
      flags_d.dir = flags_q.dir | c_dir;
      if (c_clr)                        flags_d.cmp = 1'b0;
      else if (done_pulse && flags_q.en) flags_d.cmp = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/dma_ptr_bank.sv
module dma_ptr_bank #(
  parameter int NPTR   = 5,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPTR-1:0]            wr_en,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NPTR-1:0][DATA_W-1:0] ptr_q
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    always_comb d = wr_en[i] ? wdata : q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign ptr_q[i] = q;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NPTR   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              done_pulse
);
  localparam int BE_W = DATA_W / 8;

  logic                        rst_n_s;
  logic                        word_ok, wr_ok, rd_ok;
  logic                        ctrl_hit, any_hit;
  logic [NPTR-1:0]             ptr_hit;
  logic [NPTR-1:0]             ptr_wr;
  logic [NPTR-1:0][DATA_W-1:0] ptr_q;
  flags_t                      flags;
  logic [DATA_W-1:0]           rd_mux;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign word_ok = bus_sel & (bus_be == {BE_W{1'b1}});
  assign wr_ok   = word_ok & bus_wr;
  assign rd_ok   = word_ok & ~bus_wr;

  dma_reg_decode #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_dec (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .ptr_hit(ptr_hit), .any_hit(any_hit)
  );

  assign ptr_wr = ptr_hit & {NPTR{wr_ok}};

  dma_ctrl_flags u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .ctrl_wr(wr_ok & ctrl_hit),
    .cmd(bus_wdata[CMD_LO +: CMD_W]),
    .done_pulse(done_pulse),
    .flags(flags)
  );

  dma_ptr_bank #(.NPTR(NPTR), .DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .wr_en(ptr_wr), .wdata(bus_wdata), .ptr_q(ptr_q)
  );

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) rd_mux = DATA_W'(pack_status(flags));
    for (int i = 0; i < NPTR; i++) begin
      if (ptr_hit[i]) rd_mux = rd_mux | ptr_q[i];
    end
  end

  assign bus_rdata = (rd_ok && any_hit) ? rd_mux : '0;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [3:0]  bus_be,
  input logic [15:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        done_pulse,
  input flags_t      flags
);
  logic full_acc, ctrl_wr_c, ctrl_rd_c;
  assign full_acc  = bus_sel && (bus_be == 4'hF);
  assign ctrl_wr_c = full_acc && bus_wr && (bus_addr == 16'h0000);
  assign ctrl_rd_c = full_acc && !bus_wr && (bus_addr == 16'h0000);

  assert_partial_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_be != 4'hF) |-> (bus_rdata == 32'h0));

  assert_status_layout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd_c |-> (bus_rdata[31:5] == 27'h0 && bus_rdata[2] == 1'b0 &&
                   bus_rdata[0] == flags.en && bus_rdata[4] == flags.dir));

  assert_enable_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.en && !(ctrl_wr_c && bus_wdata[CMD_RESET])) |=> flags.en);

  assert_dir_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.dir && !(ctrl_wr_c && bus_wdata[CMD_RESET])) |=> flags.dir);

  assert_clear_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_c && bus_wdata[CMD_CLR_CMP]) |=> !flags.cmp);

  assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_c && bus_wdata[CMD_RESET]) |=> (flags == '0));

  assert_complete_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.cmp) |-> ($past(flags.en) && $past(done_pulse)));

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr != 16'h0000 && bus_addr != 16'h4000 &&
     bus_addr != 16'h4004 && bus_addr != 16'h4008 && bus_addr != 16'h400C &&
     bus_addr != 16'h4200) |-> (bus_rdata == 32'h0));
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .done_pulse(done_pulse), .flags(flags)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_be;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        done_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [15:0] A_CTRL = 16'h0000, A_NEXT = 16'h4000, A_LIM = 16'h4004,
                          A_START = 16'h4008, A_STOP = 16'h400C, A_INIT = 16'h4200;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_pulse(done_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // every task starts and ends on a falling edge
  task automatic wr_acc(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 4'h0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    #1;
    chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0; bus_be = 4'h0;
  endtask

  task automatic pulse_done();
    done_pulse = 1;
    @(negedge clk);
    done_pulse = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl",  A_CTRL,  4'hF, 32'h0);
    rd_chk("R1 next",  A_NEXT,  4'hF, 32'h0);
    rd_chk("R1 limit", A_LIM,   4'hF, 32'h0);
    rd_chk("R1 start", A_START, 4'hF, 32'h0);
    rd_chk("R1 stop",  A_STOP,  4'hF, 32'h0);
    rd_chk("R1 init",  A_INIT,  4'hF, 32'h0);
  endtask

  task automatic t_pointers();
    wr_acc(A_NEXT, 32'h1111_2222, 4'hF);
    rd_chk("R3 R12 next", A_NEXT, 4'hF, 32'h1111_2222);
    wr_acc(A_LIM,   32'hA5A5_5A5A, 4'hF);
    wr_acc(A_START, 32'hDEAD_BEEF, 4'hF);
    wr_acc(A_STOP,  32'h0000_0001, 4'hF);
    wr_acc(A_INIT,  32'hFFFF_FFFF, 4'hF);
    rd_chk("R3 limit", A_LIM,   4'hF, 32'hA5A5_5A5A);
    rd_chk("R3 start", A_START, 4'hF, 32'hDEAD_BEEF);
    rd_chk("R3 stop",  A_STOP,  4'hF, 32'h0000_0001);
    rd_chk("R3 init",  A_INIT,  4'hF, 32'hFFFF_FFFF);
    rd_chk("R3 next kept", A_NEXT, 4'hF, 32'h1111_2222);
  endtask

  task automatic t_ctrl_set();
    wr_acc(A_CTRL, 32'h0001_0000, 4'hF);
    rd_chk("R5 R4 enable set", A_CTRL, 4'hF, 32'h0000_0001);
    wr_acc(A_CTRL, 32'h0000_0000, 4'hF);
    rd_chk("R5 enable sticky", A_CTRL, 4'hF, 32'h0000_0001);
    wr_acc(A_CTRL, 32'h0002_0000, 4'hF);
    rd_chk("R6 update set", A_CTRL, 4'hF, 32'h0000_0003);
    wr_acc(A_CTRL, 32'h0004_0000, 4'hF);
    rd_chk("R7 direction set", A_CTRL, 4'hF, 32'h0000_0013);
    wr_acc(A_CTRL, 32'h0000_FFFF, 4'hF);
    rd_chk("R6 R7 flags sticky", A_CTRL, 4'hF, 32'h0000_0013);
  endtask

  task automatic t_complete();
    pulse_done();
    rd_chk("R10 complete while enabled", A_CTRL, 4'hF, 32'h0000_001B);
    wr_acc(A_CTRL, 32'h0008_0000, 4'hF);
    rd_chk("R8 clear complete only", A_CTRL, 4'hF, 32'h0000_0013);
    wr_acc(A_CTRL, 32'h0017_0000, 4'hF);
    rd_chk("R9 reset wins over sets", A_CTRL, 4'hF, 32'h0000_0000);
    rd_chk("R9 pointers untouched", A_START, 4'hF, 32'hDEAD_BEEF);
    pulse_done();
    rd_chk("R10 no complete when disabled", A_CTRL, 4'hF, 32'h0000_0000);
    wr_acc(A_CTRL, 32'h0001_0000, 4'hF);
    bus_sel = 1; bus_wr = 1; bus_addr = A_CTRL; bus_be = 4'hF;
    bus_wdata = 32'h0008_0000; done_pulse = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0; done_pulse = 0;
    rd_chk("R10 clear beats event", A_CTRL, 4'hF, 32'h0000_0001);
    pulse_done();
    rd_chk("R10 event sets complete", A_CTRL, 4'hF, 32'h0000_0009);
    wr_acc(A_CTRL, 32'h0010_0000, 4'hF);
    rd_chk("R9 reset clears complete", A_CTRL, 4'hF, 32'h0000_0000);
  endtask

  task automatic t_partial();
    wr_acc(A_NEXT, 32'h7777_7777, 4'h3);
    rd_chk("R2 halfword write ignored", A_NEXT, 4'hF, 32'h1111_2222);
    rd_chk("R2 byte read zero", A_NEXT, 4'h1, 32'h0);
    wr_acc(A_CTRL, 32'h0001_0000, 4'hC);
    rd_chk("R2 partial ctrl write ignored", A_CTRL, 4'hF, 32'h0);
  endtask

  task automatic t_unmapped();
    wr_acc(16'h4010, 32'h1234_5678, 4'hF);
    wr_acc(16'h4002, 32'h1234_5678, 4'hF);
    wr_acc(16'h0004, 32'h001F_0000, 4'hF);
    rd_chk("R11 unmapped 4010", 16'h4010, 4'hF, 32'h0);
    rd_chk("R11 misaligned 4002", 16'h4002, 4'hF, 32'h0);
    rd_chk("R11 unmapped 0004", 16'h0004, 4'hF, 32'h0);
    rd_chk("R11 next unchanged", A_NEXT, 4'hF, 32'h1111_2222);
    rd_chk("R11 limit unchanged", A_LIM, 4'hF, 32'hA5A5_5A5A);
    rd_chk("R11 ctrl unchanged", A_CTRL, 4'hF, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_be = 0; bus_addr = 0;
    bus_wdata = 0; done_pulse = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pointers();
    t_ctrl_set();
    t_complete();
    t_partial();
    t_unmapped();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    #(8 * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule